// File: doc/BRIEF.md
# Reorder Buffer with Register Renaming

This block tracks in-flight micro-operations between decode and commit in an out-of-order core. Each cycle it accepts a group of up to three micro-operations in program order. Each one is given a slot in a circular tracking buffer and a fresh physical destination register taken from a free pool. Its two source operands are translated through an alias table, so a later micro-op reads the physical register that actually holds its input value. Giving each write its own physical register removes write-after-write and write-after-read hazards on architectural names. Read-after-write links survive the translation.

Execute units report progress by slot tag, in any order. An issue port moves an entry from "waiting" to "issued", and completion ports mark it "finished". Commit takes up to three finished entries per cycle from the oldest end and stops at the first entry that is not finished. Each committed micro-op returns the physical register its destination was mapped to before it, to the back of the free pool. A commit-side copy of the alias table follows every committed mapping. A flush drops all in-flight work, restores the alias table from that copy and returns the speculative registers to the pool in one cycle.

Top module: `rob_rename`

## Requirements
- R1: After reset, `alloc_ready` is 1, no `ret_valid` bit is set, architectural register i is mapped to physical register i, and the free pool holds physical registers NUM_ARCH up to NUM_PHYS-1, handed out in ascending order.
- R2: Slot tags are handed out to the accepted lanes in lane order (lane 0 oldest), consecutively from the tail. They wrap from ROB_DEPTH-1 to 0.
- R3: Each accepted micro-op receives, in lane order, the next physical register from the head of the free pool (first in, first out). `alloc_pold` reports the mapping its destination had just before it. The in-flight entry count plus the free-pool count always equals NUM_PHYS-NUM_ARCH.
- R4: `alloc_ready` is 0 when fewer than GROUP slots are empty or fewer than GROUP free registers remain. While it is 0, asserted `alloc_valid` lanes change no tag, mapping or pool state. The entry count never exceeds ROB_DEPTH.
- R5: Source operands are translated through the alias table. A source that names the destination of an earlier valid lane in the same group receives that lane's new physical register. If several earlier lanes match, the latest one is used.
- R6: When a later lane writes the same architectural register as an earlier lane of its group, its `alloc_pold` is the earlier lane's new register. On commit, the `ret_pold` value is appended to the tail of the free pool and is handed out again after the registers already in the pool.
- R7: Commit presents up to GROUP entries as a contiguous run from the oldest one (`ret_valid` bit k set implies bit k-1 set). It includes only finished entries and stops at the first entry that is not finished. An entry that is only issued does not commit. Committed lanes show the recorded architectural destination, new and old physical registers, instruction address and micro-op code.
- R8: A `flush` cycle holds `alloc_ready` low and commits nothing. From the next cycle the buffer is empty, tags restart at 0, the alias table equals the committed mappings, and the free pool is full again. Pool order resumes at the oldest register that was handed out but not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all in-flight micro-ops |
| alloc_valid | input | GROUP | Lane valid, lane 0 oldest |
| alloc_dst | input | GROUP*AW | Architectural destination per lane |
| alloc_src1 | input | GROUP*AW | First architectural source per lane |
| alloc_src2 | input | GROUP*AW | Second architectural source per lane |
| alloc_pc | input | GROUP*PC_W | Instruction address per lane |
| alloc_uop | input | GROUP*UOP_W | Micro-op code per lane |
| alloc_ready | output | 1 | Group accepted this cycle |
| alloc_tag | output | GROUP*TW | Slot tag per lane |
| alloc_pdst | output | GROUP*PW | New physical destination per lane |
| alloc_psrc1 | output | GROUP*PW | Translated first source per lane |
| alloc_psrc2 | output | GROUP*PW | Translated second source per lane |
| alloc_pold | output | GROUP*PW | Previous mapping of the destination per lane |
| disp_valid | input | 1 | Issue notification |
| disp_tag | input | TW | Tag of the issued entry |
| cmp_valid | input | NCMP | Completion notifications |
| cmp_tag | input | NCMP*TW | Tags of finished entries |
| ret_valid | output | GROUP | Committing lanes this cycle |
| ret_arch | output | GROUP*AW | Architectural destination of committed lanes |
| ret_pnew | output | GROUP*PW | Physical register becoming architectural |
| ret_pold | output | GROUP*PW | Physical register returned to the pool |
| ret_pc | output | GROUP*PC_W | Recorded instruction address |
| ret_uop | output | GROUP*UOP_W | Recorded micro-op code |

## Verification
The bench builds the block with NUM_PHYS=20 and ROB_DEPTH=6, keeping 16 architectural registers and groups of three. The free pool then has only four entries, so a single group drains it far enough to stall, and recycled registers come back out after two groups. The short buffer makes tags wrap after the second group. Flush recovery is reached with mappings both committed and in flight, so the restored pool order and the restored alias table can be checked by exact register numbers.

// File: rtl/rob_rename_pkg.sv
package rob_rename_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_ISSUED = 2'd1,
    ST_DONE   = 2'd2
  } slot_state_t;

  // (base + off) modulo depth, with off < depth
  function automatic int wrap_add(input int base, input int off, input int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // number of set bits of mask below position lane
  function automatic int lanes_before(input logic [15:0] mask, input int lane);
    int c;
    c = 0;
    for (int i = 0; i < 16; i++)
      if (i < lane && mask[i]) c = c + 1;
    return c;
  endfunction

endpackage

// File: rtl/rr_free_list.sv
module rr_free_list
  import rob_rename_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 128,
  parameter int GROUP    = 3,
  localparam int FD   = NUM_PHYS - NUM_ARCH,
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int IW   = $clog2(FD),
  localparam int CNTW = $clog2(FD + 1),
  localparam int GW   = $clog2(GROUP + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [GW-1:0]       pop_n,
  input  logic [GW-1:0]       push_n,
  input  logic [GROUP*PW-1:0] push_regs,
  output logic [GROUP*PW-1:0] head_regs,
  output logic [CNTW-1:0]     count
);

  logic [PW-1:0]   slots [FD];
  logic [IW-1:0]   head;
  logic [IW-1:0]   chead;
  logic [IW-1:0]   tail;
  logic [CNTW-1:0] cnt;

  assign count = cnt;

  always_comb begin
    for (int k = 0; k < GROUP; k++)
      head_regs[k*PW +: PW] = slots[IW'(wrap_add(int'(head), k, FD))];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      chead <= '0;
      tail  <= '0;
      cnt   <= CNTW'(FD);
      for (int i = 0; i < FD; i++) slots[i] <= PW'(NUM_ARCH + i);
    end else if (flush) begin
      head <= chead;
      cnt  <= CNTW'(FD);
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (k < int'(push_n))
          slots[IW'(wrap_add(int'(tail), k, FD))] <= push_regs[k*PW +: PW];
      head  <= IW'(wrap_add(int'(head), int'(pop_n), FD));
      chead <= IW'(wrap_add(int'(chead), int'(push_n), FD));
      tail  <= IW'(wrap_add(int'(tail), int'(push_n), FD));
      cnt   <= cnt + CNTW'(push_n) - CNTW'(pop_n);
    end
  end

endmodule

// File: rtl/rr_alias_table.sv
module rr_alias_table
  import rob_rename_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 128,
  parameter int GROUP    = 3,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [GROUP-1:0]    lane_en,
  input  logic [GROUP*AW-1:0] dst,
  input  logic [GROUP*AW-1:0] src1,
  input  logic [GROUP*AW-1:0] src2,
  input  logic [GROUP*PW-1:0] new_p,
  output logic [GROUP*PW-1:0] psrc1,
  output logic [GROUP*PW-1:0] psrc2,
  output logic [GROUP*PW-1:0] pold,
  input  logic [GROUP-1:0]    ret_en,
  input  logic [GROUP*AW-1:0] ret_arch,
  input  logic [GROUP*PW-1:0] ret_pnew
);

  logic [PW-1:0] spec_map   [NUM_ARCH];
  logic [PW-1:0] commit_map [NUM_ARCH];

  // translate one architectural name for lane k, seeing earlier lanes' writes
  function automatic logic [PW-1:0] lookup(input logic [AW-1:0] name, input int k,
                                           input logic [PW-1:0] table_val,
                                           input logic [GROUP-1:0] en,
                                           input logic [GROUP*AW-1:0] dsts,
                                           input logic [GROUP*PW-1:0] np);
    logic [PW-1:0] r;
    r = table_val;
    for (int j = 0; j < GROUP; j++)
      if (j < k && en[j] && dsts[j*AW +: AW] == name) r = np[j*PW +: PW];
    return r;
  endfunction

  always_comb begin
    for (int k = 0; k < GROUP; k++) begin
      psrc1[k*PW +: PW] = lookup(src1[k*AW +: AW], k, spec_map[src1[k*AW +: AW]],
                                 lane_en, dst, new_p);
      psrc2[k*PW +: PW] = lookup(src2[k*AW +: AW], k, spec_map[src2[k*AW +: AW]],
                                 lane_en, dst, new_p);
      pold[k*PW +: PW]  = lookup(dst[k*AW +: AW], k, spec_map[dst[k*AW +: AW]],
                                 lane_en, dst, new_p);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        spec_map[i]   <= PW'(i);
        commit_map[i] <= PW'(i);
      end
    end else if (flush) begin
      for (int i = 0; i < NUM_ARCH; i++) spec_map[i] <= commit_map[i];
    end else begin
      for (int k = 0; k < GROUP; k++) begin
        if (lane_en[k]) spec_map[dst[k*AW +: AW]] <= new_p[k*PW +: PW];
        if (ret_en[k])  commit_map[ret_arch[k*AW +: AW]] <= ret_pnew[k*PW +: PW];
      end
    end
  end

endmodule

// File: rtl/rr_rob_core.sv
module rr_rob_core
  import rob_rename_pkg::*;
#(
  parameter int ROB_DEPTH = 126,
  parameter int GROUP     = 3,
  parameter int NCMP      = 4,
  parameter int AW        = 4,
  parameter int PW        = 7,
  parameter int PC_W      = 32,
  parameter int UOP_W     = 16,
  localparam int TW = $clog2(ROB_DEPTH),
  localparam int CW = $clog2(ROB_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [GROUP-1:0]       alloc_en,
  input  logic [GROUP*AW-1:0]    alloc_dst,
  input  logic [GROUP*PW-1:0]    alloc_pnew,
  input  logic [GROUP*PW-1:0]    alloc_pold,
  input  logic [GROUP*PC_W-1:0]  alloc_pc,
  input  logic [GROUP*UOP_W-1:0] alloc_uop,
  output logic [GROUP*TW-1:0]    alloc_tag,
  input  logic                   disp_valid,
  input  logic [TW-1:0]          disp_tag,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*TW-1:0]     cmp_tag,
  output logic [GROUP-1:0]       ret_valid,
  output logic [GROUP*AW-1:0]    ret_arch,
  output logic [GROUP*PW-1:0]    ret_pnew,
  output logic [GROUP*PW-1:0]    ret_pold,
  output logic [GROUP*PC_W-1:0]  ret_pc,
  output logic [GROUP*UOP_W-1:0] ret_uop,
  output logic [CW-1:0]          count
);

  slot_state_t      st     [ROB_DEPTH];
  logic [AW-1:0]    e_arch [ROB_DEPTH];
  logic [PW-1:0]    e_pnew [ROB_DEPTH];
  logic [PW-1:0]    e_pold [ROB_DEPTH];
  logic [PC_W-1:0]  e_pc   [ROB_DEPTH];
  logic [UOP_W-1:0] e_uop  [ROB_DEPTH];

  logic [TW-1:0] head;
  logic [TW-1:0] tail;
  logic [CW-1:0] cnt;
  int            n_alloc;
  int            n_ret;

  assign count = cnt;

  always_comb begin
    n_alloc = $countones(alloc_en);
    for (int k = 0; k < GROUP; k++)
      alloc_tag[k*TW +: TW] =
        TW'(wrap_add(int'(tail), lanes_before(16'(alloc_en), k), ROB_DEPTH));
  end

  // commit window: contiguous run of finished entries from the head
  always_comb begin
    logic go;
    int   idx;
    go    = !flush;
    n_ret = 0;
    for (int k = 0; k < GROUP; k++) begin
      idx = wrap_add(int'(head), k, ROB_DEPTH);
      go  = go && (k < int'(cnt)) && (st[idx] == ST_DONE);
      ret_valid[k] = go;
      if (go) n_ret = n_ret + 1;
      ret_arch[k*AW +: AW]     = e_arch[idx];
      ret_pnew[k*PW +: PW]     = e_pnew[idx];
      ret_pold[k*PW +: PW]     = e_pold[idx];
      ret_pc[k*PC_W +: PC_W]   = e_pc[idx];
      ret_uop[k*UOP_W +: UOP_W] = e_uop[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
      for (int i = 0; i < ROB_DEPTH; i++) st[i] <= ST_WAIT;
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (alloc_en[k]) st[alloc_tag[k*TW +: TW]] <= ST_WAIT;
      if (disp_valid && st[disp_tag] == ST_WAIT) st[disp_tag] <= ST_ISSUED;
      for (int c = 0; c < NCMP; c++)
        if (cmp_valid[c]) st[cmp_tag[c*TW +: TW]] <= ST_DONE;
      head <= TW'(wrap_add(int'(head), n_ret, ROB_DEPTH));
      tail <= TW'(wrap_add(int'(tail), n_alloc, ROB_DEPTH));
      cnt  <= cnt + CW'(n_alloc) - CW'(n_ret);
    end
  end

  // payload fields need no reset: they are read only inside the live window
  always_ff @(posedge clk) begin
    for (int k = 0; k < GROUP; k++)
      if (alloc_en[k]) begin
        e_arch[alloc_tag[k*TW +: TW]] <= alloc_dst[k*AW +: AW];
        e_pnew[alloc_tag[k*TW +: TW]] <= alloc_pnew[k*PW +: PW];
        e_pold[alloc_tag[k*TW +: TW]] <= alloc_pold[k*PW +: PW];
        e_pc[alloc_tag[k*TW +: TW]]   <= alloc_pc[k*PC_W +: PC_W];
        e_uop[alloc_tag[k*TW +: TW]]  <= alloc_uop[k*UOP_W +: UOP_W];
      end
  end

endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rob_rename_pkg::*;
#(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_PHYS  = 128,
  parameter int ROB_DEPTH = 126,
  parameter int GROUP     = 3,
  parameter int NCMP      = 4,
  parameter int PC_W      = 32,
  parameter int UOP_W     = 16,
  localparam int AW   = $clog2(NUM_ARCH),
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int TW   = $clog2(ROB_DEPTH),
  localparam int CW   = $clog2(ROB_DEPTH + 1),
  localparam int FD   = NUM_PHYS - NUM_ARCH,
  localparam int CNTW = $clog2(FD + 1),
  localparam int GW   = $clog2(GROUP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [GROUP-1:0]       alloc_valid,
  input  logic [GROUP*AW-1:0]    alloc_dst,
  input  logic [GROUP*AW-1:0]    alloc_src1,
  input  logic [GROUP*AW-1:0]    alloc_src2,
  input  logic [GROUP*PC_W-1:0]  alloc_pc,
  input  logic [GROUP*UOP_W-1:0] alloc_uop,
  output logic                   alloc_ready,
  output logic [GROUP*TW-1:0]    alloc_tag,
  output logic [GROUP*PW-1:0]    alloc_pdst,
  output logic [GROUP*PW-1:0]    alloc_psrc1,
  output logic [GROUP*PW-1:0]    alloc_psrc2,
  output logic [GROUP*PW-1:0]    alloc_pold,
  input  logic                   disp_valid,
  input  logic [TW-1:0]          disp_tag,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*TW-1:0]     cmp_tag,
  output logic [GROUP-1:0]       ret_valid,
  output logic [GROUP*AW-1:0]    ret_arch,
  output logic [GROUP*PW-1:0]    ret_pnew,
  output logic [GROUP*PW-1:0]    ret_pold,
  output logic [GROUP*PC_W-1:0]  ret_pc,
  output logic [GROUP*UOP_W-1:0] ret_uop
);

  // named internal events, also observed by the bound checker
  logic [CW-1:0]       rob_count;
  logic [CNTW-1:0]     fl_count;
  logic [GROUP-1:0]    alloc_fire;
  logic [GROUP*PW-1:0] fl_head;
  logic [GW-1:0]       pop_n;
  logic [GW-1:0]       ret_n;

  assign alloc_ready = !flush
                    && (ROB_DEPTH - int'(rob_count) >= GROUP)
                    && (int'(fl_count) >= GROUP);
  assign alloc_fire  = alloc_valid & {GROUP{alloc_ready}};
  assign pop_n       = GW'($countones(alloc_fire));
  assign ret_n       = GW'($countones(ret_valid));

  always_comb begin
    for (int k = 0; k < GROUP; k++)
      alloc_pdst[k*PW +: PW] = fl_head[lanes_before(16'(alloc_fire), k)*PW +: PW];
  end

  rr_free_list #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP)
  ) i_free (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .pop_n(pop_n), .push_n(ret_n), .push_regs(ret_pold),
    .head_regs(fl_head), .count(fl_count)
  );

  rr_alias_table #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP)
  ) i_rat (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lane_en(alloc_fire), .dst(alloc_dst), .src1(alloc_src1), .src2(alloc_src2),
    .new_p(alloc_pdst), .psrc1(alloc_psrc1), .psrc2(alloc_psrc2), .pold(alloc_pold),
    .ret_en(ret_valid), .ret_arch(ret_arch), .ret_pnew(ret_pnew)
  );

  rr_rob_core #(
    .ROB_DEPTH(ROB_DEPTH), .GROUP(GROUP), .NCMP(NCMP), .AW(AW), .PW(PW),
    .PC_W(PC_W), .UOP_W(UOP_W)
  ) i_core (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(alloc_fire), .alloc_dst(alloc_dst), .alloc_pnew(alloc_pdst),
    .alloc_pold(alloc_pold), .alloc_pc(alloc_pc), .alloc_uop(alloc_uop),
    .alloc_tag(alloc_tag),
    .disp_valid(disp_valid), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_pnew(ret_pnew),
    .ret_pold(ret_pold), .ret_pc(ret_pc), .ret_uop(ret_uop),
    .count(rob_count)
  );

endmodule

// File: rtl/rob_rename_chk.sv
module rob_rename_chk #(
  parameter int ROB_DEPTH = 126,
  parameter int FD        = 112,
  parameter int GROUP     = 3,
  parameter int CW        = 7,
  parameter int CNTW      = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [GROUP-1:0] ret_valid,
  input logic [CW-1:0]   rob_count,
  input logic [CNTW-1:0] fl_count
);

  // R4: never more live entries than slots
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rob_count) <= ROB_DEPTH);

  // R3: every non-architectural register is either in flight or in the pool
  assert_reg_conserve_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rob_count) + int'(fl_count) == FD);

  // R7: commit lanes form a run starting at lane 0
  assert_ret_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + GROUP'(1)) & ret_valid) == '0);

  // R8: after a flush the buffer is empty and the pool is full
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_count == '0) && (int'(fl_count) == FD));

endmodule

bind rob_rename rob_rename_chk #(
  .ROB_DEPTH(ROB_DEPTH), .FD(FD), .GROUP(GROUP), .CW(CW), .CNTW(CNTW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ret_valid(ret_valid),
  .rob_count(rob_count), .fl_count(fl_count)
);

// File: tb/test_rob_rename.sv
module test_rob_rename;

  localparam int G = 3, NA = 16, NP = 20, D = 6, NC = 2, PCW = 16, UW = 8;
  localparam int AW = 4, PW = 5, TW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [G-1:0] alloc_valid;
  logic [AW-1:0] d_a [G], s1_a [G], s2_a [G];
  logic [PCW-1:0] pc_a [G];
  logic [UW-1:0] uop_a [G];
  logic alloc_ready;
  logic [G*TW-1:0] alloc_tag;
  logic [G*PW-1:0] alloc_pdst, alloc_psrc1, alloc_psrc2, alloc_pold;
  logic disp_valid;
  logic [TW-1:0] disp_tag;
  logic [NC-1:0] cmp_valid;
  logic [TW-1:0] ct_a [NC];
  logic [G-1:0] ret_valid;
  logic [G*AW-1:0] ret_arch;
  logic [G*PW-1:0] ret_pnew, ret_pold;
  logic [G*PCW-1:0] ret_pc;
  logic [G*UW-1:0] ret_uop;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  rob_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .ROB_DEPTH(D), .GROUP(G), .NCMP(NC),
               .PC_W(PCW), .UOP_W(UW)) i_rob_rename (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
    .alloc_dst({d_a[2], d_a[1], d_a[0]}), .alloc_src1({s1_a[2], s1_a[1], s1_a[0]}),
    .alloc_src2({s2_a[2], s2_a[1], s2_a[0]}), .alloc_pc({pc_a[2], pc_a[1], pc_a[0]}),
    .alloc_uop({uop_a[2], uop_a[1], uop_a[0]}), .alloc_ready(alloc_ready),
    .alloc_tag(alloc_tag), .alloc_pdst(alloc_pdst), .alloc_psrc1(alloc_psrc1),
    .alloc_psrc2(alloc_psrc2), .alloc_pold(alloc_pold), .disp_valid(disp_valid),
    .disp_tag(disp_tag), .cmp_valid(cmp_valid), .cmp_tag({ct_a[1], ct_a[0]}),
    .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_pnew(ret_pnew),
    .ret_pold(ret_pold), .ret_pc(ret_pc), .ret_uop(ret_uop)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int f_pc(input int dst, input int a, input int b);
    return dst * 256 + a * 16 + b;
  endfunction

  task automatic set_lane(input int k, input int dst, input int a, input int b);
    alloc_valid[k] = 1'b1;
    d_a[k] = AW'(dst); s1_a[k] = AW'(a); s2_a[k] = AW'(b);
    pc_a[k] = PCW'(f_pc(dst, a, b));
    uop_a[k] = UW'(dst + 8 * k);
  endtask

  task automatic idle();
    alloc_valid = '0; disp_valid = 0; disp_tag = '0; cmp_valid = '0; flush = 0;
    for (int k = 0; k < G; k++) begin
      d_a[k] = '0; s1_a[k] = '0; s2_a[k] = '0; pc_a[k] = '0; uop_a[k] = '0;
    end
    for (int c = 0; c < NC; c++) ct_a[c] = '0;
  endtask

  task automatic chk_lane(input string r, input int k, input int tag, input int pd,
                          input int p1, input int p2, input int po);
    chk({r, " tag"},   int'(alloc_tag[k*TW +: TW]), tag);
    chk({r, " pdst"},  int'(alloc_pdst[k*PW +: PW]), pd);
    chk({r, " psrc1"}, int'(alloc_psrc1[k*PW +: PW]), p1);
    chk({r, " psrc2"}, int'(alloc_psrc2[k*PW +: PW]), p2);
    chk({r, " pold"},  int'(alloc_pold[k*PW +: PW]), po);
  endtask

  task automatic chk_ret(input string r, input int k, input int arch, input int pn,
                         input int po);
    chk({r, " ret_arch"}, int'(ret_arch[k*AW +: AW]), arch);
    chk({r, " ret_pnew"}, int'(ret_pnew[k*PW +: PW]), pn);
    chk({r, " ret_pold"}, int'(ret_pold[k*PW +: PW]), po);
  endtask

  // R1: reset state and identity mapping
  task automatic t_reset();
    @(negedge clk);
    s1_a[0] = 4'd7; s2_a[0] = 4'd9; d_a[0] = 4'd12;
    #1;
    chk("R1 ready after reset", int'(alloc_ready), 1);
    chk("R1 no commit after reset", int'(ret_valid), 0);
    chk("R1 identity src1", int'(alloc_psrc1[0 +: PW]), 7);
    chk("R1 identity src2", int'(alloc_psrc2[0 +: PW]), 9);
    chk("R1 first pool reg", int'(alloc_pdst[0 +: PW]), 16);
    @(negedge clk); idle();
  endtask

  // R2 R3 R5 R6: first group with intra-group forwarding and WAW
  task automatic t_group_a();
    @(negedge clk);
    set_lane(0, 1, 0, 0); set_lane(1, 2, 1, 3); set_lane(2, 1, 2, 1);
    #1;
    chk("R2 ready group A", int'(alloc_ready), 1);
    chk_lane("R3 A lane0", 0, 0, 16, 0, 0, 1);
    chk_lane("R5 A lane1", 1, 1, 17, 16, 3, 2);
    chk_lane("R6 A lane2", 2, 2, 18, 17, 16, 16);
    @(negedge clk); idle();
  endtask

  // R4: pool short of a group -> stall; a stalled request changes nothing
  task automatic t_stall();
    #1;
    chk("R4 stall on empty pool", int'(alloc_ready), 0);
    set_lane(0, 5, 0, 0);
    @(negedge clk); idle();
    #1;
    chk("R4 still stalled", int'(alloc_ready), 0);
  endtask

  // R7: out-of-order completion, in-order commit
  task automatic t_ooo();
    @(negedge clk);
    cmp_valid = 2'b11; ct_a[0] = 3'd2; ct_a[1] = 3'd1;
    @(negedge clk); idle(); #1;
    chk("R7 younger done, head not", int'(ret_valid), 0);
    disp_valid = 1; disp_tag = 3'd0;
    @(negedge clk); idle(); #1;
    chk("R7 issued head does not commit", int'(ret_valid), 0);
    cmp_valid = 2'b01; ct_a[0] = 3'd0;
    @(negedge clk); idle(); #1;
    chk("R7 three commit", int'(ret_valid), 7);
    chk_ret("R7 c0", 0, 1, 16, 1);
    chk_ret("R7 c1", 1, 2, 17, 2);
    chk_ret("R7 c2", 2, 1, 18, 16);
    chk("R7 recorded pc", int'(ret_pc[0 +: PCW]), f_pc(1, 0, 0));
    chk("R7 recorded uop", int'(ret_uop[2*UW +: UW]), 1 + 16);
    @(negedge clk); #1;
    chk("R7 nothing left", int'(ret_valid), 0);
    chk("R4 ready again", int'(alloc_ready), 1);
  endtask

  // R2 R6: recycled registers, tags run up to the last slot
  task automatic t_recycle();
    set_lane(0, 5, 1, 2); set_lane(1, 3, 5, 4); set_lane(2, 4, 3, 0);
    #1;
    chk_lane("R6 B lane0", 0, 3, 19, 18, 17, 5);
    chk_lane("R6 B lane1", 1, 4, 1, 19, 4, 3);
    chk_lane("R2 B lane2", 2, 5, 2, 1, 0, 4);
    @(negedge clk); idle(); #1;
    chk("R4 stall after group B", int'(alloc_ready), 0);
  endtask

  // R8: flush restores committed mappings and pool
  task automatic t_flush();
    cmp_valid = 2'b01; ct_a[0] = 3'd4;
    @(negedge clk); idle();
    flush = 1; #1;
    chk("R8 ready low in flush", int'(alloc_ready), 0);
    chk("R8 no commit in flush", int'(ret_valid), 0);
    @(negedge clk); idle(); #1;
    chk("R8 ready after flush", int'(alloc_ready), 1);
    chk("R8 empty after flush", int'(ret_valid), 0);
    set_lane(0, 6, 1, 2); set_lane(1, 7, 5, 3); set_lane(2, 1, 4, 6);
    #1;
    chk_lane("R8 C lane0", 0, 0, 19, 18, 17, 6);
    chk_lane("R8 C lane1", 1, 1, 1, 5, 3, 7);
    chk_lane("R8 C lane2", 2, 2, 2, 4, 19, 18);
    @(negedge clk); idle();
  endtask

  // R7: commit stops at the first unfinished entry
  task automatic t_partial();
    cmp_valid = 2'b11; ct_a[0] = 3'd0; ct_a[1] = 3'd2;
    @(negedge clk); idle(); #1;
    chk("R7 stop at gap", int'(ret_valid), 1);
    chk_ret("R7 p0", 0, 6, 19, 6);
    @(negedge clk); #1;
    chk("R7 gap holds", int'(ret_valid), 0);
    cmp_valid = 2'b01; ct_a[0] = 3'd1;
    @(negedge clk); idle(); #1;
    chk("R7 gap filled", int'(ret_valid), 3);
    chk_ret("R7 q0", 0, 7, 1, 7);
    chk_ret("R7 q1", 1, 1, 2, 18);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_group_a();
    t_stall();
    t_ooo();
    t_recycle();
    t_flush();
    t_partial();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule